// File: doc/BRIEF.md
# Parallel Gini Split Evaluator

This block scores candidate threshold splits for growing a two-class decision tree. Each of sixteen lanes holds the class counts on both sides of one numeric test of the form "value ≤ threshold": how many class-0 and class-1 samples fall to the left child and how many fall to the right child. When started, every lane computes the Gini impurity of its split in 16.16 fixed point. The lanes work in parallel. A reduction stage then selects the smallest score and records which lane produced it.

Software writes the sixty-four counts through a simple register port, writes the control word to launch an evaluation, and waits for the done flag. It then reads the winning score and the winning lane index. Each lane takes a snapshot of its counts at the start, so the counts for the next batch of candidates can be loaded while the current batch is still being evaluated.

Each child's contribution is n − (a² + b²)/n, where a and b are the child's two class counts and n = a + b. This is the child's Gini impurity weighted by its size. The division by the total sample count is omitted because it is common to all candidates and does not change which one is lowest.

Top module: `gini_split_eval`

## Requirements
- R1: After reset, the done output is 0, and reads of the best-score register (address 65) and the best-index register (address 66) return 0. Reads of every count register also return 0.
- R2: The count registers sit at write/read address lane*4 + field, with lanes 0..15. The field values are: 0 = left class-0, 1 = left class-1, 2 = right class-0, 3 = right class-1. Each holds 12 bits and reads back exactly what was last written to it.
- R3: Writing a value with bit 0 set to address 64 starts an evaluation. At the clock edge that takes this write, done falls to 0. Done rises exactly 42 clock edges later and then stays at 1 until the next start. Reading address 64 returns done in bit 0.
- R4: A lane's score is the sum over its two children of n·65536 − floor((a²+b²)·65536 / n), read as an unsigned 16.16 value.
- R5: A child with zero samples contributes exactly 0 to its lane's score, and no division by zero takes place.
- R6: Once done is 1, address 65 holds the minimum score over all sixteen lanes, and address 66 holds the lane that produced it.
- R7: When several lanes share the minimum score, the lowest lane index is reported.
- R8: Count writes made while an evaluation is running do not change that evaluation's result. The next start uses the new counts.
- R9: A start issued while an evaluation is running abandons the old one. The counts present at the new start are used, and done rises 42 edges after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 12 | Register write data (count value, or bit 0 = start at address 64) |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 32 | Combinational read data |
| done | output | 1 | Evaluation finished; cleared by the next start |

## Verification
Two events can coincide inside one evaluation window: a count write and the running division, or a second start and the running division. The bench provokes both. It writes a lane into a pure split several cycles after a start. It also restarts an evaluation part way through. In each case it compares the reported minimum with one computed from the counts captured at the effective start. A per-clock model of the done flag confirms that the restart moves completion exactly 42 edges past the second start.

// File: rtl/gini_pkg.sv
package gini_pkg;
  localparam int DEF_LANES   = 16;
  localparam int DEF_CNT_W   = 12;
  localparam int DEF_FRAC_W  = 16;
  localparam int DEF_SCORE_W = 32;

  // offsets of the result registers above the count block
  typedef enum int {
    OFS_CTRL  = 0,
    OFS_SCORE = 1,
    OFS_INDEX = 2
  } reg_ofs_e;
endpackage

// File: rtl/gini_child_div.sv
module gini_child_div
  import gini_pkg::*;
#(
  parameter int CNT_W   = DEF_CNT_W,
  parameter int FRAC_W  = DEF_FRAC_W,
  parameter int SCORE_W = DEF_SCORE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [CNT_W-1:0]   cnt_a,
  input  logic [CNT_W-1:0]   cnt_b,
  output logic [CNT_W:0]     n_out,
  output logic [SCORE_W-1:0] term
);
  localparam int D_W   = CNT_W + 1;
  localparam int NUM_W = 2 * CNT_W + 1 + FRAC_W;

  logic [D_W-1:0]   n_q, rem_q;
  logic [NUM_W-1:0] quo_q;

  wire [D_W-1:0]   n_in  = D_W'(cnt_a) + D_W'(cnt_b);
  wire [NUM_W-1:0] sq_in = (NUM_W'(cnt_a) * NUM_W'(cnt_a) + NUM_W'(cnt_b) * NUM_W'(cnt_b)) << FRAC_W;

  wire [D_W:0] r_sh = {rem_q, quo_q[NUM_W-1]};
  wire         take = (r_sh >= {1'b0, n_q});

  function automatic logic [SCORE_W-1:0] child_term(input logic [D_W-1:0] n, input logic [NUM_W-1:0] q);
    if (n == '0) return '0;
    return SCORE_W'({n, {FRAC_W{1'b0}}}) - SCORE_W'(q);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q   <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      n_q   <= n_in;
      rem_q <= '0;
      quo_q <= sq_in;
    end else if (step) begin
      if (take) begin
        rem_q <= D_W'(r_sh - {1'b0, n_q});
        quo_q <= {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_q <= r_sh[D_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], 1'b0};
      end
    end
  end

  assign n_out = n_q;
  assign term  = child_term(n_q, quo_q);

  // R4: the partial remainder never reaches the divisor
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && n_q != '0) |=> (rem_q < n_q));
endmodule

// File: rtl/gini_lane.sv
module gini_lane
  import gini_pkg::*;
#(
  parameter int CNT_W   = DEF_CNT_W,
  parameter int FRAC_W  = DEF_FRAC_W,
  parameter int SCORE_W = DEF_SCORE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               result_ok,
  input  logic [CNT_W-1:0]   left_c0,
  input  logic [CNT_W-1:0]   left_c1,
  input  logic [CNT_W-1:0]   right_c0,
  input  logic [CNT_W-1:0]   right_c1,
  output logic [SCORE_W-1:0] score
);
  logic [CNT_W:0]     n_left, n_right;
  logic [SCORE_W-1:0] term_left, term_right;

  gini_child_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SCORE_W(SCORE_W)) u_left (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .cnt_a(left_c0), .cnt_b(left_c1), .n_out(n_left), .term(term_left));

  gini_child_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SCORE_W(SCORE_W)) u_right (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .cnt_a(right_c0), .cnt_b(right_c1), .n_out(n_right), .term(term_right));

  assign score = term_left + term_right;

  // R4: weighted two-class impurity never exceeds half the sample count
  a_r4_score_bound: assert property (@(posedge clk) disable iff (!rst_n)
    result_ok |-> (score <= ((SCORE_W'(n_left) + SCORE_W'(n_right)) << (FRAC_W - 1))));
endmodule

// File: rtl/gini_min_reduce.sv
module gini_min_reduce
  import gini_pkg::*;
#(
  parameter int LANES   = DEF_LANES,
  parameter int SCORE_W = DEF_SCORE_W,
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic [LANES-1:0][SCORE_W-1:0] scores,
  output logic [SCORE_W-1:0]            min_score,
  output logic [IDX_W-1:0]              min_idx
);
  // strict compare: an equal later lane never displaces an earlier one
  always_comb begin
    min_score = scores[0];
    min_idx   = '0;
    for (int i = 1; i < LANES; i++) begin
      if (scores[i] < min_score) begin
        min_score = scores[i];
        min_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/gini_split_eval.sv
module gini_split_eval
  import gini_pkg::*;
#(
  parameter int LANES   = DEF_LANES,
  parameter int CNT_W   = DEF_CNT_W,
  parameter int FRAC_W  = DEF_FRAC_W,
  parameter int SCORE_W = DEF_SCORE_W,
  localparam int N_REGS = LANES * 4,
  localparam int ADDR_W = $clog2(N_REGS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [SCORE_W-1:0] rd_data,
  output logic               done
);
  localparam int IDX_W  = $clog2(LANES);
  localparam int NUM_W  = 2 * CNT_W + 1 + FRAC_W;
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(N_REGS + OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SCORE = ADDR_W'(N_REGS + OFS_SCORE);
  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(N_REGS + OFS_INDEX);

  logic [CNT_W-1:0]   cnt_q [N_REGS];
  logic               run_q, done_q;
  logic [STEP_W-1:0]  step_q;
  logic [SCORE_W-1:0] best_q;
  logic [IDX_W-1:0]   idx_q;

  logic [LANES-1:0][SCORE_W-1:0] lane_score;
  logic [SCORE_W-1:0]            red_score;
  logic [IDX_W-1:0]              red_idx;

  // named events for the checks
  wire cnt_wr_evt = wr_en && !wr_addr[ADDR_W-1];
  wire start_evt  = wr_en && (wr_addr == A_CTRL) && wr_data[0];
  wire iter_evt   = run_q && (step_q < STEP_W'(NUM_W)) && !start_evt;
  wire finish_evt = run_q && (step_q == STEP_W'(NUM_W)) && !start_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) cnt_q[i] <= '0;
    end else if (cnt_wr_evt) begin
      cnt_q[wr_addr[ADDR_W-2:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
      best_q <= '0;
      idx_q  <= '0;
    end else if (start_evt) begin
      run_q  <= 1'b1;
      step_q <= '0;
      done_q <= 1'b0;
    end else if (finish_evt) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
      best_q <= red_score;
      idx_q  <= red_idx;
    end else if (iter_evt) begin
      step_q <= step_q + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    gini_lane #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SCORE_W(SCORE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(start_evt), .step(iter_evt), .result_ok(done_q),
      .left_c0(cnt_q[4*g]), .left_c1(cnt_q[4*g+1]),
      .right_c0(cnt_q[4*g+2]), .right_c1(cnt_q[4*g+3]),
      .score(lane_score[g]));

    // R6: the captured minimum is no larger than any lane's score
    a_r6_best_is_min: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (best_q <= lane_score[g]));
    // R7: on an equal score the reported lane is not above this one
    a_r7_low_index_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && lane_score[g] == best_q) |-> (idx_q <= IDX_W'(g)));
  end

  gini_min_reduce #(.LANES(LANES), .SCORE_W(SCORE_W)) u_reduce (
    .scores(lane_score), .min_score(red_score), .min_idx(red_idx));

  always_comb begin
    rd_data = '0;
    if (!rd_addr[ADDR_W-1])      rd_data = SCORE_W'(cnt_q[rd_addr[ADDR_W-2:0]]);
    else if (rd_addr == A_CTRL)  rd_data = SCORE_W'(done_q);
    else if (rd_addr == A_SCORE) rd_data = best_q;
    else if (rd_addr == A_INDEX) rd_data = SCORE_W'(idx_q);
  end

  assign done = done_q;

  // R3: a start always clears done at its own edge
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !done_q);
  // R3: done holds until the next start
  a_r3_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_evt) |=> done_q);
  // R9: done cannot rise while the division is still stepping
  a_r9_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    iter_evt |=> !done_q);
endmodule

// File: tb/gini_split_eval_bench.sv
`timescale 1ns/1ps
module gini_split_eval_bench;
  localparam int LAT    = 2 * 12 + 17 + 1;  // 42 edges from start to done
  localparam int A_CTRL = 64;
  localparam int A_SC   = 65;
  localparam int A_IX   = 66;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        done;

  gini_split_eval u_gini_split_eval (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done));

  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  int cnt [64];
  longint exp_best = 0;
  int exp_idx = 0;
  bit exp_done = 1'b0;
  bit start_flag = 1'b0;
  int countdown = 0;
  int seed = 32'h1234_5678;

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint child(input int a, input int b);
    longint n = longint'(a) + b;
    if (n == 0) return 0;
    return n * 65536 - ((longint'(a) * a + longint'(b) * b) * 65536) / n;
  endfunction

  // per-clock model of the done flag (R3, R9)
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      exp_done = 1'b0; countdown = 0;
    end else begin
      if (start_flag) begin
        start_flag = 1'b0; exp_done = 1'b0; countdown = LAT;
      end else if (countdown > 0) begin
        countdown--;
        if (countdown == 0) exp_done = 1'b1;
      end
      check("R3 done timing", done, exp_done);
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(addr); wr_data = 12'(data);
    if (addr < 64) cnt[addr] = data & 12'hFFF;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_lane(input int l, input int a0, input int a1, input int b0, input int b1);
    wr(l*4, a0); wr(l*4+1, a1); wr(l*4+2, b0); wr(l*4+3, b1);
  endtask

  task automatic start_eval();
    longint s;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(A_CTRL); wr_data = 12'd1;
    start_flag = 1'b1;
    exp_best = -1; exp_idx = 0;
    for (int l = 0; l < 16; l++) begin
      s = child(cnt[l*4], cnt[l*4+1]) + child(cnt[l*4+2], cnt[l*4+3]);
      if (exp_best < 0 || s < exp_best) begin exp_best = s; exp_idx = l; end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output longint v);
    rd_addr = 7'(addr);
    #0.5;
    v = longint'(rd_data);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (exp_done) break;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input string req);
    longint v;
    wait_done();
    rd(A_CTRL, v); check({req, " done reg"}, v, 1);
    rd(A_SC, v);   check({req, " best score"}, v, exp_best);
    rd(A_IX, v);   check({req, " best index"}, v, exp_idx);
  endtask

  function automatic int rnd(input int m);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7FFF_FFFF) % m;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint v;
    for (int i = 0; i < 64; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 done", done, 0);
    rd(A_SC, v); check("R1 score reg", v, 0);
    rd(A_IX, v); check("R1 index reg", v, 0);
    rd(37, v);   check("R1 count reg", v, 0);

    // R2 field layout and readback
    set_lane(7, 11, 22, 33, 4095);
    rd(28, v); check("R2 left c0", v, 11);
    rd(29, v); check("R2 left c1", v, 22);
    rd(30, v); check("R2 right c0", v, 33);
    rd(31, v); check("R2 right c1", v, 4095);
    wr(63, 1234);
    rd(63, v); check("R2 last field", v, 1234);

    // R5 and R7: every lane empty
    for (int i = 0; i < 64; i++) wr(i, 0);
    start_eval();
    check_result("R5 all empty");

    // R4/R6 directed: balanced background, one better lane
    for (int l = 0; l < 16; l++) set_lane(l, 100, 100, 100, 100);
    set_lane(11, 30, 10, 5, 25);
    start_eval();
    check_result("R4 lane 11 best");
    check("R6 directed index", exp_idx, 11);

    // R5: one empty child in the winning lane
    set_lane(11, 100, 100, 100, 100);
    set_lane(2, 0, 0, 7, 3);
    start_eval();
    check_result("R5 empty left child");

    // R7: tie between pure splits in lanes 4, 9, 12
    set_lane(4, 50, 0, 0, 50);
    set_lane(9, 50, 0, 0, 50);
    set_lane(12, 0, 9, 9, 0);
    start_eval();
    check_result("R7 tie");
    check("R7 lowest lane", exp_idx, 4);

    // R4/R6 pseudo-random rounds
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 64; i++) wr(i, rnd(4096));
      start_eval();
      check_result("R6 random");
    end

    // R8: write a pure split during the run
    for (int l = 0; l < 16; l++) set_lane(l, 40, 60, 70, 30);
    start_eval();
    repeat (5) @(negedge clk);
    set_lane(5, 80, 0, 0, 80);
    check_result("R8 snapshot kept");
    rd(20, v); check("R8 new count stored", v, 80);
    start_eval();
    check_result("R8 new counts used");
    check("R8 new winner", exp_idx, 5);

    // R9: restart part way through
    set_lane(5, 40, 60, 70, 30);
    start_eval();
    repeat (10) @(negedge clk);
    set_lane(14, 3, 0, 0, 9);
    start_eval();
    check_result("R9 restart");
    check("R9 restart winner", exp_idx, 14);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule